// File: doc/BRIEF.md
# Flash Busy-Status Bit Generator

This block builds the status byte that a host sees when it reads a NOR flash while an internal program or erase is running. The array algorithms are not part of it. An outside sequencer starts an operation with `op_start` and `op_kind`, and later ends it with `alg_done` or `alg_fail`. Between those events the block tracks the operation in a small state machine. For each read strobe it returns a data-polling bit, two toggle bits, an erase-window bit and a time-limit bit. It also drives an active-high `ready` line.

The states are:

- **IDLE**: array reads.
- **PROG**: program running.
- **PROT**: pseudo-busy pulse for a program aimed at a protected sector.
- **SERASE**: sector erase running.
- **ESUSP**: sector erase suspended.
- **CERASE**: chip erase running.
- **FAIL**: an algorithm reported failure.

The transitions are:

- **IDLE→PROG / PROT / SERASE / CERASE**: an accepted start.
- **PROG→IDLE** on done. **PROT→IDLE** when the pulse timer ends.
- **SERASE→IDLE** on done. **SERASE→ESUSP** on a suspend after the window has closed. **ESUSP→SERASE** on resume.
- **CERASE→IDLE** on done.
- **PROG / SERASE / CERASE→FAIL** on fail. **FAIL→IDLE** on a reset command.
- **any→IDLE** on hardware reset.

A cycle timer holds the sector-erase acceptance window open. A second timer sets the length of the protected-sector pulse.

Each read returns `rd_status` and `rd_is_status`. Both are captured at the clock edge where `rd_strobe` is sampled high, and both reflect the state before that edge. The toggle bits change on read strobes, not on clock cycles.

Top module: `nor_busy_status`

## Requirements
- R1: After hardware reset, `ready` is 1, the machine is in IDLE, both toggle bits are 0, and a read returns `rd_status`=0x00 with `rd_is_status`=0.
- R2: A program start (`op_kind`=2'b00) accepted in IDLE drives `ready` to 0 from the next cycle until done or fail. During the program, and after a program fail, bit 7 of the status byte equals the inverse of `prog_bit7` as sampled at start.
- R3: In PROG, PROT, SERASE, CERASE and FAIL, bit 6 flips after every read strobe, so successive reads return opposite values. In IDLE and ESUSP it holds.
- R4: A program start with `target_protected`=1 enters PROT. `ready` is then 0 for exactly PROT_CYCLES cycles, after which the block returns to IDLE without `alg_done`.
- R5: Bit 3 is 0 in SERASE while the window is open and 1 after it closes. The window is open for WINDOW_CYCLES cycles after the erase start. An `erase_add` while the window is open restarts it, and an `erase_add` after it has closed is ignored. Bit 3 is 1 in CERASE and ESUSP and 0 elsewhere.
- R6: Bit 2 flips after a read with `rd_in_erase`=1 in SERASE, ESUSP or CERASE. Reads with `rd_in_erase`=0 leave it unchanged.
- R7: `suspend_req` moves SERASE to ESUSP only once the window is closed. In ESUSP `ready` is 1, bit 7 is 1 and bit 6 is frozen, and `alg_done` and `alg_fail` are ignored. `resume_req` returns the block to SERASE.
- R8: In CERASE, `suspend_req`, `reset_cmd` and `erase_add` are ignored. Only done, fail or hardware reset end the chip erase.
- R9: `alg_fail` moves the block to FAIL. There `ready` is 1, bit 5 is 1 and bit 6 keeps flipping on reads, until `reset_cmd` returns the block to IDLE.
- R10: Hardware reset (`rst_n`=0) ends any operation at once and restores the R1 state.
- R11: `op_start` is ignored outside IDLE, and also when `op_kind`=2'b11.
- R12: `rd_is_status` is 1 for reads in PROG, PROT, SERASE, CERASE and FAIL. In ESUSP it is 1 only when `rd_in_erase`=1. In IDLE it is 0. The status byte layout is {bit7 poll, bit6 toggle, bit5 time limit, 0, bit3 window, bit2 toggle, 0, 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| op_start | input | 1 | Start of an embedded operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 none |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| target_protected | input | 1 | Program target lies in a protected sector |
| erase_add | input | 1 | Further sector-erase command |
| suspend_req | input | 1 | Erase suspend command |
| resume_req | input | 1 | Erase resume command |
| reset_cmd | input | 1 | Reset command write |
| alg_done | input | 1 | Algorithm finished successfully |
| alg_fail | input | 1 | Algorithm exceeded its time limit |
| rd_strobe | input | 1 | Host read strobe |
| rd_in_erase | input | 1 | Read address is in a sector being erased or suspended |
| rd_status | output | 8 | Captured status byte |
| rd_is_status | output | 1 | Captured byte replaces array data |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
`ready` responds to a start, done, fail, suspend or resume one cycle after the edge that samples the command. The bench therefore checks it at the falling edge that follows. A read result appears one cycle after the strobe edge. The driver queues each expected byte when it raises the strobe, and the monitor compares it at the next falling edge.

The window and pulse checks place their stimuli at counted cycles with several cycles of margin on each side of each boundary. The pulse length is measured by counting busy falling edges.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        OPK_PROG   = 2'b00,
        OPK_SERASE = 2'b01,
        OPK_CERASE = 2'b10,
        OPK_NONE   = 2'b11
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PROT,
        ST_SERASE,
        ST_ESUSP,
        ST_CERASE,
        ST_FAIL
    } nbs_state_e;

    typedef struct packed {
        logic b7;
        logic b5;
        logic b3;
        logic tog6_en;
        logic tog2_en;
        logic status_all;
        logic status_zone;
    } nbs_view_t;

endpackage

// File: rtl/nbs_cycle_timer.sv
module nbs_cycle_timer #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clear,
    output logic [W-1:0] remaining
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(LIMIT);
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign remaining = cnt_q;

    // R5: an expired timer stays expired until it is loaded again
    a_r5_timer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/nbs_ctrl_fsm.sv
module nbs_ctrl_fsm
    import nbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_start,
    input  logic [1:0]  op_kind,
    input  logic        prog_bit7,
    input  logic        target_protected,
    input  logic        erase_add,
    input  logic        suspend_req,
    input  logic        resume_req,
    input  logic        reset_cmd,
    input  logic        alg_done,
    input  logic        alg_fail,
    input  logic        win_open,
    input  logic        prot_last,
    output logic        win_load,
    output logic        prot_load,
    output nbs_state_e  state,
    output nbs_view_t   view,
    output logic        ready
);

    nbs_state_e state_q, state_nx;
    op_kind_e   kind;
    logic       poll_q;

    assign kind      = op_kind_e'(op_kind);
    assign win_load  = (state_q == ST_IDLE && op_start && kind == OPK_SERASE)
                     || (state_q == ST_SERASE && erase_add && win_open);
    assign prot_load = state_q == ST_IDLE && op_start && kind == OPK_PROG && target_protected;
    assign state     = state_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start) begin
                    unique case (kind)
                        OPK_PROG:   state_nx = target_protected ? ST_PROT : ST_PROG;
                        OPK_SERASE: state_nx = ST_SERASE;
                        OPK_CERASE: state_nx = ST_CERASE;
                        default:    state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_PROG: begin
                if (alg_fail)      state_nx = ST_FAIL;
                else if (alg_done) state_nx = ST_IDLE;
            end
            ST_PROT: begin
                if (prot_last) state_nx = ST_IDLE;
            end
            ST_SERASE: begin
                if (alg_fail)                      state_nx = ST_FAIL;
                else if (alg_done)                 state_nx = ST_IDLE;
                else if (suspend_req && !win_open) state_nx = ST_ESUSP;
            end
            ST_ESUSP: begin
                if (resume_req) state_nx = ST_SERASE;
            end
            ST_CERASE: begin
                if (alg_fail)      state_nx = ST_FAIL;
                else if (alg_done) state_nx = ST_IDLE;
            end
            ST_FAIL: begin
                if (reset_cmd) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            poll_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE && op_start)
                poll_q <= (kind == OPK_PROG) ? ~prog_bit7 : 1'b0;
        end
    end

    always_comb begin
        view  = '0;
        ready = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_PROG, ST_PROT: begin
                ready           = 1'b0;
                view.b7         = poll_q;
                view.tog6_en    = 1'b1;
                view.status_all = 1'b1;
            end
            ST_SERASE: begin
                ready           = 1'b0;
                view.b3         = !win_open;
                view.tog6_en    = 1'b1;
                view.tog2_en    = 1'b1;
                view.status_all = 1'b1;
            end
            ST_ESUSP: begin
                view.b7          = 1'b1;
                view.b3          = 1'b1;
                view.tog2_en     = 1'b1;
                view.status_zone = 1'b1;
            end
            ST_CERASE: begin
                ready           = 1'b0;
                view.b3         = 1'b1;
                view.tog6_en    = 1'b1;
                view.tog2_en    = 1'b1;
                view.status_all = 1'b1;
            end
            ST_FAIL: begin
                view.b7         = poll_q;
                view.b5         = 1'b1;
                view.tog6_en    = 1'b1;
                view.status_all = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: an accepted unprotected program start makes the block busy
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_start && kind == OPK_PROG && !target_protected) |=> !ready);

    // R7: no suspend while the erase window is open
    a_r7_no_early_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERASE && win_open) |=> (state_q != ST_ESUSP));

    // R8: chip erase only ends by done or fail
    a_r8_chip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CERASE && !alg_done && !alg_fail) |=> (state_q == ST_CERASE));

    // R9: failure persists until the reset command
    a_r9_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL && !reset_cmd) |=> (state_q == ST_FAIL && ready));

    // R11: the reserved kind starts nothing
    a_r11_no_kind_none: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_start && kind == OPK_NONE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/nbs_read_bits.sv
module nbs_read_bits
    import nbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_strobe,
    input  logic        rd_in_erase,
    input  nbs_view_t   view,
    output logic [7:0]  rd_status,
    output logic        rd_is_status
);

    logic tog6_q, tog2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog6_q       <= 1'b0;
            tog2_q       <= 1'b0;
            rd_status    <= '0;
            rd_is_status <= 1'b0;
        end else if (rd_strobe) begin
            rd_status    <= {view.b7, tog6_q, view.b5, 1'b0, view.b3, tog2_q, 2'b00};
            rd_is_status <= view.status_all | (view.status_zone & rd_in_erase);
            if (view.tog6_en)
                tog6_q <= ~tog6_q;
            if (view.tog2_en && rd_in_erase)
                tog2_q <= ~tog2_q;
        end
    end

    // R3: each read while busy flips bit 6
    a_r3_tog6_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && view.tog6_en) |=> (tog6_q != $past(tog6_q)));

    // R7: with bit 6 frozen (idle, suspended) reads leave it alone
    a_r7_tog6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!view.tog6_en) |=> $stable(tog6_q));

    // R6: bit 2 only moves on reads inside the erase zone
    a_r6_tog2_zone: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe || !rd_in_erase) |=> $stable(tog2_q));

endmodule

// File: rtl/nor_busy_status.sv
module nor_busy_status
    import nbs_pkg::*;
#(
    parameter int unsigned WINDOW_CYCLES = 12500,
    parameter int unsigned PROT_CYCLES   = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic       prog_bit7,
    input  logic       target_protected,
    input  logic       erase_add,
    input  logic       suspend_req,
    input  logic       resume_req,
    input  logic       reset_cmd,
    input  logic       alg_done,
    input  logic       alg_fail,
    input  logic       rd_strobe,
    input  logic       rd_in_erase,
    output logic [7:0] rd_status,
    output logic       rd_is_status,
    output logic       ready
);

    localparam int unsigned WIN_W  = $clog2(WINDOW_CYCLES + 1);
    localparam int unsigned PROT_W = $clog2(PROT_CYCLES + 1);

    nbs_state_e        state;
    nbs_view_t         view;
    logic              win_load, prot_load;
    logic [WIN_W-1:0]  win_left;
    logic [PROT_W-1:0] prot_left;
    logic              win_open, prot_last;

    assign win_open  = win_left != '0;
    assign prot_last = prot_left == PROT_W'(1);

    nbs_ctrl_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .op_start         (op_start),
        .op_kind          (op_kind),
        .prog_bit7        (prog_bit7),
        .target_protected (target_protected),
        .erase_add        (erase_add),
        .suspend_req      (suspend_req),
        .resume_req       (resume_req),
        .reset_cmd        (reset_cmd),
        .alg_done         (alg_done),
        .alg_fail         (alg_fail),
        .win_open         (win_open),
        .prot_last        (prot_last),
        .win_load         (win_load),
        .prot_load        (prot_load),
        .state            (state),
        .view             (view),
        .ready            (ready)
    );

    nbs_cycle_timer #(.LIMIT(WINDOW_CYCLES)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (win_load),
        .clear     (state != ST_SERASE),
        .remaining (win_left)
    );

    nbs_cycle_timer #(.LIMIT(PROT_CYCLES)) u_prot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (prot_load),
        .clear     (state != ST_PROT),
        .remaining (prot_left)
    );

    nbs_read_bits u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_strobe    (rd_strobe),
        .rd_in_erase  (rd_in_erase),
        .view         (view),
        .rd_status    (rd_status),
        .rd_is_status (rd_is_status)
    );

    // R4: the protected pulse ends on its own
    a_r4_prot_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROT && prot_last) |=> (state == ST_IDLE && ready));

endmodule

// File: tb/test_nor_busy_status.sv
module test_nor_busy_status;

    localparam int unsigned WIN  = 20;
    localparam int unsigned PROT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, prog_bit7 = 0, target_protected = 0, erase_add = 0;
    logic suspend_req = 0, resume_req = 0, reset_cmd = 0, alg_done = 0, alg_fail = 0;
    logic rd_strobe = 0, rd_in_erase = 0;
    logic [1:0] op_kind = 2'b00;
    logic [7:0] rd_status;
    logic rd_is_status, ready;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic e6 = 0, e2 = 0;
    logic [8:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    nor_busy_status #(.WINDOW_CYCLES(WIN), .PROT_CYCLES(PROT)) i_nor_busy_status (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .prog_bit7(prog_bit7), .target_protected(target_protected), .erase_add(erase_add),
        .suspend_req(suspend_req), .resume_req(resume_req), .reset_cmd(reset_cmd),
        .alg_done(alg_done), .alg_fail(alg_fail), .rd_strobe(rd_strobe),
        .rd_in_erase(rd_in_erase), .rd_status(rd_status), .rd_is_status(rd_is_status),
        .ready(ready)
    );

    task automatic chk(input logic ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ready(input logic exp, input string tag);
        chk(ready === exp, tag, {8'h00, ready}, {8'h00, exp});
    endtask

    // driver: queue expected {is_status, byte}, strobe for one cycle
    task automatic rd(input logic zone, input logic b7, input logic b5, input logic b3,
                      input logic tg6, input logic tg2, input logic is, input string tag);
        exp_q.push_back({is, b7, e6, b5, 1'b0, b3, e2, 2'b00});
        tag_q.push_back(tag);
        rd_strobe   = 1'b1;
        rd_in_erase = zone;
        @(negedge clk);
        rd_strobe = 1'b0;
        if (tg6) e6 = ~e6;
        if (tg2) e2 = ~e2;
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            if (rd_strobe) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "unexpected read", {rd_is_status, rd_status}, 9'h000);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({rd_is_status, rd_status} === e, t, {rd_is_status, rd_status}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk_ready(1'b1, "R1 ready after reset");
        rd(0, 0, 0, 0, 0, 0, 0, "R1 idle read");

        // program, bit7 = 1 -> poll 0
        op_kind = 2'b00; prog_bit7 = 1'b1; op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;
        chk_ready(1'b0, "R2 busy after start");
        rd(1, 0, 0, 0, 1, 0, 1, "R3 program read a");
        rd(1, 0, 0, 0, 1, 0, 1, "R3 program read b");
        alg_done = 1'b1; @(negedge clk); alg_done = 1'b0;
        chk_ready(1'b1, "R2 ready after done");
        rd(0, 0, 0, 0, 0, 0, 0, "R3 idle hold a");
        rd(0, 0, 0, 0, 0, 0, 0, "R12 idle not status");

        // program, bit7 = 0 -> poll 1, then fail
        prog_bit7 = 1'b0; op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;
        rd(0, 1, 0, 0, 1, 0, 1, "R2 poll inverse");
        alg_fail = 1'b1; @(negedge clk); alg_fail = 1'b0;
        chk_ready(1'b1, "R9 ready on fail");
        rd(0, 1, 1, 0, 1, 0, 1, "R9 fail read a");
        rd(0, 1, 1, 0, 1, 0, 1, "R9 fail read b");
        op_start = 1'b1; @(negedge clk); op_start = 1'b0;
        chk_ready(1'b1, "R11 start ignored in fail");
        rd(0, 1, 1, 0, 1, 0, 1, "R11 still failed");
        reset_cmd = 1'b1; @(negedge clk); reset_cmd = 1'b0;
        rd(0, 0, 0, 0, 0, 0, 0, "R9 reset command clears");

        // protected program pulse
        begin
            int n = 0;
            target_protected = 1'b1; op_start = 1'b1;
            @(negedge clk); op_start = 1'b0; target_protected = 1'b0;
            for (int i = 0; i < 50; i++) begin
                if (ready) break;
                n++;
                @(negedge clk);
            end
            chk(n == PROT, "R4 pulse length", 9'(n), 9'(PROT));
        end

        // sector erase with window extension
        op_kind = 2'b01; op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;          // after E0
        wait_n(7);                                // after E7
        erase_add = 1'b1; @(negedge clk); erase_add = 1'b0;   // sampled E8
        suspend_req = 1'b1; @(negedge clk); suspend_req = 1'b0; // sampled E9, window open
        chk_ready(1'b0, "R7 suspend ignored in window");
        wait_n(5);                                // after E14
        rd(1, 0, 0, 0, 1, 1, 1, "R5 window open");        // E15
        wait_n(6);                                // after E22
        rd(1, 0, 0, 0, 1, 1, 1, "R5 window extended");    // E23
        wait_n(9);                                // after E33
        rd(1, 0, 0, 1, 1, 1, 1, "R5 window closed");      // E34
        erase_add = 1'b1; @(negedge clk); erase_add = 1'b0;
        rd(1, 0, 0, 1, 1, 1, 1, "R5 late add ignored");
        rd(0, 0, 0, 1, 1, 0, 1, "R6 outside zone");
        suspend_req = 1'b1; @(negedge clk); suspend_req = 1'b0;
        chk_ready(1'b1, "R7 suspended ready");
        rd(1, 1, 0, 1, 0, 1, 1, "R7 suspended read");
        rd(1, 1, 0, 1, 0, 1, 1, "R6 suspended zone toggles");
        rd(0, 1, 0, 1, 0, 0, 0, "R12 suspended outside zone");
        alg_done = 1'b1; @(negedge clk); alg_done = 1'b0;
        chk_ready(1'b1, "R7 done ignored in suspend");
        rd(1, 1, 0, 1, 0, 1, 1, "R7 still suspended");
        resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
        chk_ready(1'b0, "R7 resumed busy");
        rd(1, 0, 0, 1, 1, 1, 1, "R7 resumed read");
        alg_done = 1'b1; @(negedge clk); alg_done = 1'b0;
        chk_ready(1'b1, "R2 erase done ready");

        // chip erase
        op_kind = 2'b10; op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;
        rd(1, 0, 0, 1, 1, 1, 1, "R8 chip read");
        suspend_req = 1'b1; @(negedge clk); suspend_req = 1'b0;
        reset_cmd = 1'b1; @(negedge clk); reset_cmd = 1'b0;
        erase_add = 1'b1; @(negedge clk); erase_add = 1'b0;
        chk_ready(1'b0, "R8 commands ignored");
        rd(1, 0, 0, 1, 1, 1, 1, "R8 chip still running");
        rst_n = 1'b0; @(negedge clk);
        chk_ready(1'b1, "R10 hw reset aborts");
        rst_n = 1'b1; e6 = 1'b0; e2 = 1'b0;
        @(negedge clk);
        rd(1, 0, 0, 0, 0, 0, 0, "R10 state after hw reset");

        // reserved kind
        op_kind = 2'b11; op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;
        chk_ready(1'b1, "R11 reserved kind");
        rd(0, 0, 0, 0, 0, 0, 0, "R11 still idle");

        wait_n(2);
        chk(exp_q.size() == 0, "all reads seen", 9'(exp_q.size()), 9'd0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule